// File: doc/BRIEF.md
# Four-Channel Compare Timer with PWM Outputs

This block is a timer peripheral with four independent channels behind a simple 16-bit register port. Each channel owns a 16-bit up-counter driven by a selectable prescaled clock edge, four 16-bit compare values (A to D), a clear-source selector, a mode field and a 3-bit output code that controls one output pin. A shared run register holds one bit per channel, so software can start or stop any channel without touching the others.

In PWM mode a channel restarts its counter on a match with the chosen compare register. At that restart the pin returns to a programmed starting level. When the counter then reaches compare A, the pin takes a new level given by a match action code. Compare A can be rewritten while the channel runs, which changes the duty cycle without disturbing the period. A stopped channel keeps both its count and its pin level, and writing the output code drives the pin straight to the new starting level. Software can use this to park the pin at a fixed level.

Top module: `mtu_pwm`

## Requirements
- R1: Register offset 0x00 is the run register: bit n (n = 0..3) lets channel n count when 1 and freezes it when 0. Bits [15:4] read as 0. A write takes effect from the next clock edge.
- R2: Channel n is decoded at base 0x10 + 0x40*n with these offsets: control 0x00 (bits [7:0] stored), mode 0x04 (bits 6,5,4,1,0 stored; the upper three have no effect), output code 0x08 (bits [2:0]), counter 0x14, compare A/B/C/D at 0x18/0x1C/0x20/0x24. Offsets 0x0C and 0x10, and every other address, read 0 and ignore writes.
- R3: Reset clears every register, counter and run bit, and drives all pins low.
- R4: A counting channel increments its counter by one per counting edge and wraps from 0xFFFF to 0. A channel whose run bit is 0 holds its counter.
- R5: Control bits [7:5] choose the clear source: 1 = A, 2 = B, 5 = C, 6 = D, any other value = never clear. On a counting edge where the counter equals the selected compare value, the counter becomes 0 instead of incrementing.
- R6: Control bits [1:0] choose the divide ratio 1, 4, 16 or 64. Control bits [4:3] choose the edge of the prescaled clock: 0 rising, 1 falling, 2 or 3 both. At ratio 1 every clock cycle is a counting edge. Over any 64 consecutive cycles a running channel makes exactly 64/ratio counting edges, or twice that with both edges at ratios 4 to 64.
- R7: A write to the output code sets the pin to code bit 2 at that clock edge, even while the channel is halted. A halted channel never changes its pin otherwise.
- R8: In PWM mode (mode bits [1:0] = 2), a counting edge that clears the counter sets the pin to code bit 2. Otherwise, when the counter equals compare A, code bits [1:0] act on the pin: 0 none, 1 low, 2 high, 3 invert. Clearing takes priority over the A action.
- R9: In any mode other than PWM, compare matches leave the pin unchanged.
- R10: A new compare A value is used from the next counting edge after its write, and the counter continues without restarting.
- R11: A counter write loads the written value and overrides counting on that edge. The pin is not changed on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_pin | output | CH (4) | One output pin per channel |

## Verification
A wrong count or a wrong clear decision shows up on the counter readback on the very next counting edge. A bad PWM state shows up on the pin within one period: the edge comes too early or too late, or the level is wrong after a restart. The bench predicts every cycle of the counter and the pin from a model built from the requirements, so a single-edge slip is caught in the cycle it happens. Prescaler faults only show as a wrong number of counts over a 64-cycle window. For that reason each divide and edge setting is checked as a count total, which does not depend on the phase of the shared divider.

// File: rtl/mtu_pwm.sv
module mtu_pwm #(
  parameter int CH = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic [CH-1:0] pwm_pin
);
  localparam int CH_BASE = 16;
  localparam int IDX_W = AW - 6;

  logic [5:0]       pre;
  logic [CH-1:0]    run;
  logic [7:0]       ctl [CH];
  logic [4:0]       md [CH];
  logic [2:0]       oc [CH];
  logic [15:0]      cnt [CH];
  logic [15:0]      ca [CH];
  logic [15:0]      cmp_b [CH];
  logic [15:0]      cc [CH];
  logic [15:0]      cd [CH];
  logic             pin_q [CH];

  logic [AW-1:0]    rel;
  logic [IDX_W-1:0] idx;
  logic [5:0]       off;
  logic             ch_hit;

  assign rel    = bus_addr - AW'(CH_BASE);
  assign idx    = rel[AW-1:6];
  assign off    = rel[5:0];
  assign ch_hit = bus_addr >= AW'(CH_BASE);

  function automatic logic edge_tick(input logic [5:0] p, input logic [1:0] div,
                                     input logic [1:0] edg);
    logic [5:0] mask;
    logic r, f;
    case (div)
      2'd1:    mask = 6'h03;
      2'd2:    mask = 6'h0F;
      default: mask = 6'h3F;
    endcase
    r = (p & mask) == (mask >> 1);
    f = (p & mask) == mask;
    if (div == 2'd0)       return 1'b1;
    else if (edg == 2'd0)  return r;
    else if (edg == 2'd1)  return f;
    else                   return r | f;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      run <= '0;
    end else begin
      pre <= pre + 6'd1;
      if (bus_we && bus_addr == '0) run <= bus_wdata[CH-1:0];
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic sel, wr_cnt, go, clr;
    assign sel    = bus_we && ch_hit && idx == IDX_W'(i);
    assign wr_cnt = sel && off == 6'h14;
    assign go     = run[i] && edge_tick(pre, ctl[i][1:0], ctl[i][4:3]) && !wr_cnt;

    always_comb begin
      case (ctl[i][7:5])
        3'd1:    clr = cnt[i] == ca[i];
        3'd2:    clr = cnt[i] == cmp_b[i];
        3'd5:    clr = cnt[i] == cc[i];
        3'd6:    clr = cnt[i] == cd[i];
        default: clr = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl[i] <= '0; md[i] <= '0; oc[i] <= '0; cnt[i] <= '0;
        ca[i] <= '0; cmp_b[i] <= '0; cc[i] <= '0; cd[i] <= '0;
        pin_q[i] <= 1'b0;
      end else begin
        if (sel && off == 6'h00) ctl[i] <= bus_wdata[7:0];
        if (sel && off == 6'h04) md[i] <= {bus_wdata[6:4], bus_wdata[1:0]};
        if (sel && off == 6'h18) ca[i] <= bus_wdata;
        if (sel && off == 6'h1C) cmp_b[i] <= bus_wdata;
        if (sel && off == 6'h20) cc[i] <= bus_wdata;
        if (sel && off == 6'h24) cd[i] <= bus_wdata;
        if (sel && off == 6'h08) oc[i] <= bus_wdata[2:0];

        if (wr_cnt)  cnt[i] <= bus_wdata;
        else if (go) cnt[i] <= clr ? '0 : cnt[i] + 16'd1;

        if (sel && off == 6'h08) pin_q[i] <= bus_wdata[2];
        else if (go && md[i][1:0] == 2'd2) begin
          if (clr) pin_q[i] <= oc[i][2];
          else if (cnt[i] == ca[i]) begin
            case (oc[i][1:0])
              2'd1:    pin_q[i] <= 1'b0;
              2'd2:    pin_q[i] <= 1'b1;
              2'd3:    pin_q[i] <= ~pin_q[i];
              default: pin_q[i] <= pin_q[i];
            endcase
          end
        end
      end
    end

    assign pwm_pin[i] = pin_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata[CH-1:0] = run;
    for (int i = 0; i < CH; i++) begin
      if (ch_hit && idx == IDX_W'(i)) begin
        case (off)
          6'h00:   bus_rdata = {8'h00, ctl[i]};
          6'h04:   bus_rdata = {9'h000, md[i][4:2], 2'b00, md[i][1:0]};
          6'h08:   bus_rdata = {13'h0000, oc[i]};
          6'h14:   bus_rdata = cnt[i];
          6'h18:   bus_rdata = ca[i];
          6'h1C:   bus_rdata = cmp_b[i];
          6'h20:   bus_rdata = cc[i];
          6'h24:   bus_rdata = cd[i];
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

module mtu_pwm_chk #(
  parameter int CH = 4,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input logic [CH-1:0] pwm_pin,
  input logic [CH-1:0] run,
  input logic [15:0]   cnt [CH],
  input logic [7:0]    ctl [CH],
  input logic [15:0]   cmp_b [CH]
);
  always_comb begin
    if (rst_n === 1'b1 && bus_addr >= AW'(2) && bus_addr < AW'(16))
      assert_unmapped_zero_R2: assert (bus_rdata == 16'h0000);
  end

  for (genvar i = 0; i < CH; i++) begin : g_chk
    localparam logic [AW-1:0] CNT_A = AW'(16 + 64 * i + 20);
    localparam logic [AW-1:0] OC_A  = AW'(16 + 64 * i + 8);

    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] && !(bus_we && bus_addr == CNT_A) |=> $stable(cnt[i]));

    assert_clear_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run[i] && ctl[i][1:0] == 2'd0 && ctl[i][7:5] == 3'd2 && cnt[i] == cmp_b[i]
      && !(bus_we && bus_addr == CNT_A) |=> cnt[i] == 16'h0000);

    assert_code_sets_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == OC_A |=> pwm_pin[i] == $past(bus_wdata[2]));

    assert_halt_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] && !(bus_we && bus_addr == OC_A) |=> $stable(pwm_pin[i]));
  end
endmodule

bind mtu_pwm mtu_pwm_chk #(.CH(CH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_pin(pwm_pin),
  .run(run), .cnt(cnt), .ctl(ctl), .cmp_b(cmp_b)
);

// File: tb/mtu_pwm_test.sv
module mtu_pwm_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pwm_pin;

  int checks = 0;
  int fails = 0;

  mtu_pwm uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
               .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_pin(pwm_pin));

  always #(CLK_P / 2) clk = ~clk;

  // {addr, write data, expected readback}
  localparam logic [39:0] VEC [14] = '{
    {8'h00, 16'hFFF0, 16'h0000},
    {8'hD0, 16'hFFFF, 16'h00FF},
    {8'hD4, 16'hFFFF, 16'h0073},
    {8'hD8, 16'hFFFF, 16'h0007},
    {8'hDC, 16'hFFFF, 16'h0000},
    {8'hE0, 16'hFFFF, 16'h0000},
    {8'hE8, 16'h1234, 16'h1234},
    {8'hEC, 16'hABCD, 16'hABCD},
    {8'hF0, 16'h5A5A, 16'h5A5A},
    {8'hF4, 16'hC3C3, 16'hC3C3},
    {8'hE4, 16'h0042, 16'h0042},
    {8'hF8, 16'hFFFF, 16'h0000},
    {8'h04, 16'hFFFF, 16'h0000},
    {8'h54, 16'h0003, 16'h0003}
  };

  // {control value, expected count after 64 cycles}
  localparam logic [15:0] PRE_VEC [6] = '{
    {8'h01, 8'd16}, {8'h09, 8'd16}, {8'h12, 8'd8},
    {8'h1B, 8'd2},  {8'h03, 8'd1},  {8'h18, 8'd64}
  };

  logic [15:0] m_cnt, m_a, m_clr_val;
  logic        m_pin, m_start, m_clr_on, m_pwm;
  logic [1:0]  m_act;
  int          cur_ch;
  logic [15:0] ch0_saved;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  function automatic logic [7:0] base(input int ch);
    return 8'(16 + 64 * ch);
  endfunction

  task automatic m_step;
    logic clr;
    clr = m_clr_on && m_cnt == m_clr_val;
    if (m_pwm) begin
      if (clr) m_pin = m_start;
      else if (m_cnt == m_a) begin
        case (m_act)
          2'd1: m_pin = 1'b0;
          2'd2: m_pin = 1'b1;
          2'd3: m_pin = ~m_pin;
          default: m_pin = m_pin;
        endcase
      end
    end
    m_cnt = clr ? 16'h0000 : m_cnt + 16'd1;
  endtask

  task automatic cmp_state(input string tag);
    rd_check(base(cur_ch) + 8'h14, m_cnt, {tag, " count"});
    chk({tag, " pin"}, {15'h0, pwm_pin[cur_ch]}, {15'h0, m_pin});
  endtask

  task automatic run_check(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      m_step;
      cmp_state(tag);
    end
  endtask

  task automatic hold_check(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_state(tag);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    chk("R3 pins after reset", {12'h0, pwm_pin}, 16'h0000);
    rd_check(8'h00, 16'h0000, "R3 run reg");
    rd_check(8'h10, 16'h0000, "R3 ch0 control");
    rd_check(8'h24, 16'h0000, "R3 ch0 counter");
    rd_check(8'hEC, 16'h0000, "R3 ch3 compare B");

    // R2 / R1: register map walk
    for (int v = 0; v < 14; v++) begin
      wr(VEC[v][39:32], VEC[v][31:16]);
      rd_check(VEC[v][39:32], VEC[v][15:0], "R2 R1 register readback");
    end

    // R8: PWM on ch0, clear on B, start high, drive low at A
    cur_ch = 0;
    wr(8'h10, 16'h0040); wr(8'h14, 16'h0002);
    wr(8'h28, 16'd3); wr(8'h2C, 16'd7); wr(8'h24, 16'd0);
    wr(8'h18, 16'h0005);
    m_cnt = 0; m_a = 3; m_clr_on = 1; m_clr_val = 7;
    m_start = 1; m_act = 2'd1; m_pwm = 1; m_pin = 1;
    cmp_state("R7 code write while halted");
    wr(8'h00, 16'h0001);
    run_check(20, "R8 pwm high-then-low");

    // R10: change A while running
    wr(8'h28, 16'd5); m_step; m_a = 5;
    cmp_state("R10 A write edge");
    run_check(16, "R10 new duty");

    // R11: counter write while running
    wr(8'h24, 16'd6); m_cnt = 6;
    cmp_state("R11 counter write");
    run_check(10, "R11 after load");

    // R4 / R1: halt holds count and pin
    wr(8'h00, 16'h0000); m_step;
    hold_check(6, "R4 halted hold");

    // R7: code write while halted, then inverse polarity
    wr(8'h18, 16'h0002); m_pin = 0; m_start = 0; m_act = 2'd2;
    cmp_state("R7 pin to start level");
    wr(8'h00, 16'h0001);
    run_check(16, "R8 low-then-high");

    // R8: invert action
    wr(8'h00, 16'h0000); m_step;
    wr(8'h18, 16'h0007); m_pin = 1; m_start = 1; m_act = 2'd3;
    wr(8'h00, 16'h0001);
    run_check(16, "R8 invert action");

    // R8: A equal to B, clear wins
    wr(8'h00, 16'h0000); m_step;
    wr(8'h28, 16'd7); m_a = 7;
    wr(8'h00, 16'h0001);
    run_check(16, "R8 clear priority");

    // R9: normal mode leaves the pin alone
    wr(8'h00, 16'h0000); m_step;
    wr(8'h14, 16'h0000); m_pwm = 0;
    wr(8'h28, 16'd3); m_a = 3;
    wr(8'h18, 16'h0005); m_pin = 1; m_start = 1; m_act = 2'd1;
    wr(8'h00, 16'h0001);
    run_check(16, "R9 normal mode");
    wr(8'h00, 16'h0000); m_step;
    ch0_saved = m_cnt;

    // R4 / R5: clear sources on ch1
    cur_ch = 1;
    wr(8'h54, 16'h0000); m_pwm = 0; m_pin = 0;
    wr(8'h50, 16'h0000); wr(8'h64, 16'hFFFD);
    m_cnt = 16'hFFFD; m_clr_on = 0;
    wr(8'h00, 16'h0002);
    run_check(6, "R4 wrap");
    wr(8'h00, 16'h0000); m_step;

    wr(8'h50, 16'h0020); wr(8'h68, 16'd2); wr(8'h64, 16'd0);
    m_cnt = 0; m_clr_on = 1; m_clr_val = 2; m_a = 2;
    wr(8'h00, 16'h0002);
    run_check(8, "R5 clear on A");
    wr(8'h00, 16'h0000); m_step;

    wr(8'h50, 16'h00A0); wr(8'h70, 16'd4); wr(8'h64, 16'd0);
    m_cnt = 0; m_clr_val = 4;
    wr(8'h00, 16'h0002);
    run_check(10, "R5 clear on C");
    wr(8'h00, 16'h0000); m_step;

    wr(8'h50, 16'h00C0); wr(8'h74, 16'd1); wr(8'h64, 16'd0);
    m_cnt = 0; m_clr_val = 1;
    wr(8'h00, 16'h0002);
    run_check(6, "R5 clear on D");
    wr(8'h00, 16'h0000); m_step;

    wr(8'h50, 16'h0060); wr(8'h64, 16'd0);
    m_cnt = 0; m_clr_on = 0;
    wr(8'h00, 16'h0002);
    run_check(5, "R5 code 3 never clears");
    wr(8'h00, 16'h0000); m_step;

    // R6: prescaler and edge choice
    for (int p = 0; p < 6; p++) begin
      wr(8'h50, {8'h00, PRE_VEC[p][15:8]});
      wr(8'h64, 16'd0);
      wr(8'h00, 16'h0002);
      repeat (63) @(negedge clk);
      wr(8'h00, 16'h0000);
      rd_check(8'h64, {8'h00, PRE_VEC[p][7:0]}, "R6 counts per 64 cycles");
    end

    // R1: ch0 untouched while ch1 ran
    rd_check(8'h24, ch0_saved, "R1 other channel held");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule